// File: doc/BRIEF.md
# EDAC Read-Cycle Sequencer

This controller drives the two mode lines of a decode-only error detection and correction unit that sits between a memory and a processor. Between reads it parks the unit in encode mode. When a read is requested it selects the start-read mode and waits for the memory to report valid data. It then moves the unit into the latch-and-flag mode, which captures the 22-bit word and enables the single and double error flags. After a programmable settle time it samples those flags.

A clean word ends the read at once, and the processor takes data straight from memory. A lone single-error flag sends the unit into correct mode. After a second settle time the sequencer samples the syndrome and ends the read with the corrected path selected. A raised double-error flag ends the read and sets an interrupt, which holds until it is acknowledged.

Every completed read updates a status register with the flags and the syndrome. A run tracker raises a hard-error line when the same nonzero syndrome appears on a programmable number of consecutive single-error reads.

Mode encoding (`mode_hi`, `mode_lo`): 00 encode/idle, 01 start read, 11 latch and flag, 10 correct and output syndrome.

States: IDLE (00), START (01), LATCH (11), CORRECT (10), DONE (00). Transitions:
- IDLE→START on `rd_req`.
- START→LATCH on `mem_valid`.
- LATCH→DONE when the settle time expires with no flag, or with `flag_double` high.
- LATCH→CORRECT when it expires with only `flag_single` high.
- CORRECT→DONE when the settle time expires.
- DONE→IDLE always.

Top module: `edac_rdseq`

## Requirements
- R1: After reset the modes are 00, and `busy`, `rd_done`, `sel_corrected`, `irq`, `hard_err` and all status outputs are 0.
- R2: `rd_req` in IDLE gives mode 01 from the next cycle. That mode holds for as long as `mem_valid` stays low.
- R3: `mem_valid` in mode 01 gives mode 11 from the next cycle. Mode 11 lasts exactly max(`settle_cfg`,1) cycles, and the flags are sampled in its last cycle.
- R4: When neither flag is sampled high, the read goes straight to DONE with `sel_corrected`=0 and mode 10 never appears.
- R5: When `flag_single`=1 and `flag_double`=0 are sampled, mode 10 follows for exactly max(`settle_cfg`,1) cycles. `syndrome_in` is sampled in its last cycle, and DONE follows with `sel_corrected`=1.
- R6: When `flag_double`=1 is sampled, the read goes straight to DONE with `sel_corrected`=0 and `irq` becomes 1 in the DONE cycle.
- R7: `irq` stays 1 until a cycle with `irq_ack`=1, and is 0 from the next cycle. A new double error in the same cycle as the acknowledge keeps it set.
- R8: In DONE, `stat_single`/`stat_double` show the sampled flags. `stat_syndrome` shows the sampled syndrome on the correct path, or 0 otherwise. These values hold until the next DONE.
- R9: `hard_err` is 1 once the same nonzero syndrome has completed RUN_LEN (default 3) consecutive single-error reads. Any clean read, double-error read or zero-syndrome read clears the run. A different nonzero syndrome restarts the run at one.
- R10: `rd_done` is high for exactly one cycle, the DONE cycle, with modes 00. `rd_req` seen during DONE is ignored, and the cycle after DONE is IDLE with `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Start a read sequence (taken in IDLE) |
| mem_valid | input | 1 | Memory output data is valid |
| flag_single | input | 1 | Single-error flag from the EDAC |
| flag_double | input | 1 | Double-error flag from the EDAC |
| syndrome_in | input | SYN_W | Syndrome presented by the EDAC in correct mode |
| settle_cfg | input | SETTLE_W | Settle cycles per mode step (0 treated as 1) |
| irq_ack | input | 1 | Clears the interrupt |
| mode_hi | output | 1 | Upper mode line to the EDAC |
| mode_lo | output | 1 | Lower mode line to the EDAC |
| busy | output | 1 | A read sequence is in progress |
| rd_done | output | 1 | One-cycle read completion pulse |
| sel_corrected | output | 1 | Data source: 1 corrected path, 0 memory |
| irq | output | 1 | Uncorrectable-error interrupt |
| stat_single | output | 1 | Status: single flag of last read |
| stat_double | output | 1 | Status: double flag of last read |
| stat_syndrome | output | SYN_W | Status: syndrome of last read |
| hard_err | output | 1 | Repeated-syndrome hard fault |

## Verification
The bench goes after the settle count at 0 and 1. A timer that mishandles zero would give a mode step of 16 cycles or of none, and an off-by-one would stretch every step. It sends a double-error read with both flags high. A design that tests the single flag first would wrongly enter correct mode and never interrupt. Syndrome runs are interrupted by clean reads, double-error reads, zero syndromes and different syndromes. A tracker that fails to restart its run would report a hard fault too early or keep one set after the run breaks. The interrupt is held for several idle cycles before the acknowledge, to catch a flag that clears itself. A request raised in the DONE cycle checks that the sequencer does not restart.

// File: rtl/edac_rdseq_pkg.sv
package edac_rdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LATCH,
        ST_CORRECT,
        ST_DONE
    } seq_state_t;

    // Mode pair driven onto the EDAC: {hi, lo}
    localparam logic [1:0] MODE_ENCODE  = 2'b00;
    localparam logic [1:0] MODE_START   = 2'b01;
    localparam logic [1:0] MODE_LATCH   = 2'b11;
    localparam logic [1:0] MODE_CORRECT = 2'b10;

endpackage

// File: rtl/edac_rdseq_timer.sv
module edac_rdseq_timer #(
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                run,
    input  logic [SETTLE_W-1:0] limit,
    output logic                expired
);
    logic [SETTLE_W-1:0] cnt_q;
    logic [SETTLE_W-1:0] last_idx;

    // Zero settle behaves as one cycle
    always_comb begin
        if (limit == '0) begin
            last_idx = '0;
        end else begin
            last_idx = limit - SETTLE_W'(1);
        end
        expired = (cnt_q == last_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + SETTLE_W'(1);
        end
    end

endmodule

// File: rtl/edac_rdseq_hardtrack.sv
module edac_rdseq_hardtrack #(
    parameter int SYN_W   = 6,
    parameter int RUN_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             single_ok,
    input  logic [SYN_W-1:0] syn,
    output logic             hard
);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0]    run_q;
    logic [SYN_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= '0;
        end else if (upd) begin
            if (single_ok && (syn != '0)) begin
                last_q <= syn;
                if ((syn == last_q) && (run_q != '0)) begin
                    if (run_q != RW'(RUN_LEN)) begin
                        run_q <= run_q + RW'(1);
                    end
                end else begin
                    run_q <= RW'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign hard = (run_q >= RW'(RUN_LEN));

endmodule

// File: rtl/edac_rdseq.sv
module edac_rdseq
    import edac_rdseq_pkg::*;
#(
    parameter int SYN_W    = 6,
    parameter int SETTLE_W = 4,
    parameter int RUN_LEN  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic                mem_valid,
    input  logic                flag_single,
    input  logic                flag_double,
    input  logic [SYN_W-1:0]    syndrome_in,
    input  logic [SETTLE_W-1:0] settle_cfg,
    input  logic                irq_ack,
    output logic                mode_hi,
    output logic                mode_lo,
    output logic                busy,
    output logic                rd_done,
    output logic                sel_corrected,
    output logic                irq,
    output logic                stat_single,
    output logic                stat_double,
    output logic [SYN_W-1:0]    stat_syndrome,
    output logic                hard_err
);
    seq_state_t state_q, state_d;

    logic tmr_clr, tmr_run, tmr_exp;
    logic latch_end, corr_end;
    logic go_correct, dbl_seen;
    logic finish;
    logic [1:0] mode;

    edac_rdseq_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .limit   (settle_cfg),
        .expired (tmr_exp)
    );

    assign latch_end  = (state_q == ST_LATCH)   && tmr_exp;
    assign corr_end   = (state_q == ST_CORRECT) && tmr_exp;
    assign dbl_seen   = latch_end && flag_double;
    assign go_correct = latch_end && flag_single && !flag_double;
    assign finish     = (latch_end && !go_correct) || corr_end;
    assign tmr_clr    = ((state_q == ST_START) && mem_valid) || go_correct;
    assign tmr_run    = (state_q == ST_LATCH) || (state_q == ST_CORRECT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (rd_req)    state_d = ST_START;
            ST_START:   if (mem_valid) state_d = ST_LATCH;
            ST_LATCH: begin
                if (go_correct) begin
                    state_d = ST_CORRECT;
                end else if (tmr_exp) begin
                    state_d = ST_DONE;
                end
            end
            ST_CORRECT: if (tmr_exp)   state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Mode and handshake outputs
    always_comb begin
        mode    = MODE_ENCODE;
        rd_done = 1'b0;
        unique case (state_q)
            ST_IDLE:    mode = MODE_ENCODE;
            ST_START:   mode = MODE_START;
            ST_LATCH:   mode = MODE_LATCH;
            ST_CORRECT: mode = MODE_CORRECT;
            ST_DONE:    rd_done = 1'b1;
            default:    mode = MODE_ENCODE;
        endcase
        mode_hi = mode[1];
        mode_lo = mode[0];
        busy    = (state_q != ST_IDLE);
    end

    // Status register and data-source select, loaded as a read finishes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_corrected <= 1'b0;
            stat_single   <= 1'b0;
            stat_double   <= 1'b0;
            stat_syndrome <= '0;
        end else if (finish) begin
            sel_corrected <= corr_end;
            stat_single   <= corr_end ? 1'b1 : flag_single;
            stat_double   <= corr_end ? 1'b0 : flag_double;
            stat_syndrome <= corr_end ? syndrome_in : '0;
        end
    end

    // Interrupt: set wins over acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (dbl_seen) begin
            irq <= 1'b1;
        end else if (irq_ack) begin
            irq <= 1'b0;
        end
    end

    edac_rdseq_hardtrack #(.SYN_W(SYN_W), .RUN_LEN(RUN_LEN)) u_hard (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (finish),
        .single_ok (corr_end),
        .syn       (syndrome_in),
        .hard      (hard_err)
    );

endmodule

// File: rtl/edac_rdseq_chk.sv
module edac_rdseq_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic mem_valid,
    input logic flag_single,
    input logic flag_double,
    input logic irq_ack,
    input logic mode_hi,
    input logic mode_lo,
    input logic busy,
    input logic rd_done,
    input logic sel_corrected,
    input logic irq
);
    // R1: idle parks the EDAC in encode mode
    a_r1_idle_encode: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mode_hi && !mode_lo));

    // R2: request in idle selects start-read mode
    a_r2_start_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_req) |=> (!mode_hi && mode_lo));

    // R3: valid data in start mode leads to latch mode
    a_r3_latch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_hi && mode_lo && mem_valid) |=> (mode_hi && mode_lo));

    // R5: correct mode entered only after a lone single flag
    a_r5_correct_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hi && !mode_lo && $past(mode_hi && mode_lo))
            |-> $past(flag_single && !flag_double));

    // R7: interrupt holds without acknowledge
    a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R4: memory path selected on a finished read with no correction step
    a_r4_direct_path: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && $past(mode_hi && mode_lo)) |-> !sel_corrected);

endmodule

bind edac_rdseq edac_rdseq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req        (rd_req),
    .mem_valid     (mem_valid),
    .flag_single   (flag_single),
    .flag_double   (flag_double),
    .irq_ack       (irq_ack),
    .mode_hi       (mode_hi),
    .mode_lo       (mode_lo),
    .busy          (busy),
    .rd_done       (rd_done),
    .sel_corrected (sel_corrected),
    .irq           (irq)
);

// File: tb/edac_rdseq_bench.sv
module edac_rdseq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SYN_W      = 6;
    localparam int SETTLE_W   = 4;
    localparam int RUN_LEN    = 3;
    localparam int WD_CYCLES  = 100000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rd_req = 1'b0;
    logic                mem_valid = 1'b0;
    logic                flag_single = 1'b0;
    logic                flag_double = 1'b0;
    logic [SYN_W-1:0]    syndrome_in = '0;
    logic [SETTLE_W-1:0] settle_cfg = '0;
    logic                irq_ack = 1'b0;
    logic                mode_hi, mode_lo, busy, rd_done, sel_corrected, irq;
    logic                stat_single, stat_double, hard_err;
    logic [SYN_W-1:0]    stat_syndrome;

    int checks = 0;
    int fails  = 0;
    int exp_run = 0;
    logic [SYN_W-1:0] exp_last = '0;
    bit exp_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edac_rdseq #(.SYN_W(SYN_W), .SETTLE_W(SETTLE_W), .RUN_LEN(RUN_LEN)) u_edac_rdseq (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .mem_valid(mem_valid),
        .flag_single(flag_single), .flag_double(flag_double),
        .syndrome_in(syndrome_in), .settle_cfg(settle_cfg), .irq_ack(irq_ack),
        .mode_hi(mode_hi), .mode_lo(mode_lo), .busy(busy), .rd_done(rd_done),
        .sel_corrected(sel_corrected), .irq(irq), .stat_single(stat_single),
        .stat_double(stat_double), .stat_syndrome(stat_syndrome), .hard_err(hard_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic int eff_settle(input int s);
        return (s == 0) ? 1 : s;
    endfunction

    // Expected hard-fault run after a finished read (R9)
    function automatic void model_run(input bit corr, input logic [SYN_W-1:0] syn);
        if (corr && syn != '0) begin
            if (syn == exp_last && exp_run != 0) begin
                if (exp_run < RUN_LEN) exp_run++;
            end else begin
                exp_run = 1;
            end
            exp_last = syn;
        end else begin
            exp_run = 0;
        end
    endfunction

    task automatic do_read(input int settle, input bit sng, input bit dbl,
                           input logic [SYN_W-1:0] syn, input int gap);
        int  n;
        bit  corr;
        int  mode_now;
        settle_cfg  = SETTLE_W'(settle);
        flag_single = sng;
        flag_double = dbl;
        syndrome_in = syn;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(!mode_hi && mode_lo, "R2 start mode", {mode_hi, mode_lo}, 1);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(!mode_hi && mode_lo, "R2 start held", {mode_hi, mode_lo}, 1);
        end
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        n = 0;
        while (mode_hi && mode_lo && n < 40) begin
            n++;
            @(negedge clk);
        end
        check(n == eff_settle(settle), "R3 latch length", n, eff_settle(settle));
        corr = sng && !dbl;
        n = 0;
        while (mode_hi && !mode_lo && n < 40) begin
            n++;
            @(negedge clk);
        end
        if (corr) begin
            check(n == eff_settle(settle), "R5 correct length", n, eff_settle(settle));
        end else begin
            check(n == 0, "R4 no correct step", n, 0);
        end
        mode_now = {mode_hi, mode_lo};
        check(rd_done && mode_now == 0, "R10 done cycle", {rd_done, mode_hi, mode_lo}, 4);
        if (corr) check(sel_corrected == 1'b1, "R5 corrected path", sel_corrected, 1);
        else if (dbl) check(sel_corrected == 1'b0, "R6 memory path", sel_corrected, 0);
        else check(sel_corrected == 1'b0, "R4 memory path", sel_corrected, 0);
        if (dbl) exp_irq = 1'b1;
        check(irq == exp_irq, "R6 irq", irq, exp_irq);
        check(stat_single == (corr ? 1'b1 : sng), "R8 stat single", stat_single, corr ? 1 : sng);
        check(stat_double == dbl, "R8 stat double", stat_double, dbl);
        check(stat_syndrome == (corr ? syn : '0), "R8 stat syndrome",
              stat_syndrome, corr ? syn : 0);
        model_run(corr, syn);
        check(hard_err == (exp_run >= RUN_LEN), "R9 hard fault", hard_err, exp_run >= RUN_LEN);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(!rd_done && !busy && !mode_hi && !mode_lo, "R10 back to idle",
              {rd_done, busy, mode_hi, mode_lo}, 0);
        @(negedge clk);
        check(!busy, "R10 request in done ignored", busy, 0);
        check(stat_syndrome == (corr ? syn : '0), "R8 status held",
              stat_syndrome, corr ? syn : 0);
    endtask

    task automatic ack_irq();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(irq == 1'b1, "R7 irq held", irq, 1);
        end
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        exp_irq = 1'b0;
        check(irq == 1'b0, "R7 irq cleared", irq, 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
    end

    initial begin
        logic [SYN_W-1:0] pool [3];
        pool[0] = 6'h0B;
        pool[1] = 6'h15;
        pool[2] = 6'h00;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(!mode_hi && !mode_lo && !busy && !rd_done, "R1 reset modes",
              {mode_hi, mode_lo, busy, rd_done}, 0);
        check(!irq && !hard_err && !sel_corrected, "R1 reset flags",
              {irq, hard_err, sel_corrected}, 0);
        check(!stat_single && !stat_double && stat_syndrome == 0, "R1 reset status",
              {stat_single, stat_double, stat_syndrome}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        do_read(0, 0, 0, 6'h00, 0);                 // R4 clean, zero settle
        do_read(1, 1, 0, 6'h2C, 2);                 // R5 single, settle 1
        do_read(4, 1, 0, 6'h2C, 1);
        do_read(2, 1, 0, 6'h2C, 0);                 // R9 third in run
        do_read(3, 1, 0, 6'h2C, 0);                 // R9 stays saturated
        do_read(2, 1, 0, 6'h13, 0);                 // R9 different syndrome restarts
        do_read(1, 1, 1, 6'h13, 3);                 // R6 both flags
        ack_irq();
        do_read(0, 0, 1, 6'h00, 0);                 // R6 double only
        // R7 set wins over simultaneous acknowledge is not reachable idle; ack now
        ack_irq();
        do_read(2, 1, 0, 6'h00, 1);                 // R9 zero syndrome clears run

        // Random reads
        for (int i = 0; i < 60; i++) begin
            int kind = $urandom_range(0, 3);
            int st   = $urandom_range(0, 5);
            int gp   = $urandom_range(0, 3);
            logic [SYN_W-1:0] sy = pool[$urandom_range(0, 2)];
            if (kind == 0)      do_read(st, 0, 0, sy, gp);
            else if (kind == 3) do_read(st, $urandom_range(0, 1), 1, sy, gp);
            else                do_read(st, 1, 0, sy, gp);
            if (exp_irq) ack_irq();
        end
        summary();
    end

endmodule